// File: doc/BRIEF.md
# SPI Clock and Chip-Select Timing Generator

This block derives the serial clock and the chip-select waveform of an SPI master from a fast system clock. A sequencer asks for a frame with a one-cycle start strobe. The block asserts chip select, waits a programmed setup time and then runs SCK one period after another. A one-cycle stop strobe ends the frame at the end of the current SCK period. Chip select then stays active for a programmed hold time, and a programmed idle gap follows before the next frame can begin.

The high and low phases of SCK have separate counts, each the number of system cycles minus one. Setup, hold and idle are also counts minus one, measured in whole SCK periods. Clock polarity, clock phase, a sample-edge swap and chip-select polarity are inputs. Alongside SCK and CS, the block emits one-cycle shift and sample pulses aligned with the SCK edges, so a separate data shifter can move bits. It also pulses a frame-done strobe once the idle gap has elapsed. Every count and mode bit is captured when a frame is accepted. The extended-timing parameter selects 16-bit phase, setup and hold counts, or 8-bit counts when it is off. The idle count is always 8 bits wide.

Top module: `spi_edge_timer`

## Requirements
- R1: While reset is held and while no frame is running, SCK equals the clock-polarity input, CS is at its inactive level, and the shift, sample and frame-done outputs are low.
- R2: A start strobe is accepted only when no frame is running. CS goes active in the cycle after the start is sampled. A start sampled during a frame has no effect on that frame.
- R3: With P = (high count + 1) + (low count + 1) system cycles, the first SCK edge appears (setup count + 1) * P cycles after CS goes active.
- R4: While the frame runs, SCK stays high for (high count + 1) system cycles and low for (low count + 1) system cycles. A count of zero gives a phase of one cycle.
- R5: SCK rests at the polarity level outside the active periods. The leading edge of each period leaves that level: it is a rising edge when polarity is 0 and a falling edge when polarity is 1.
- R6: Shift and sample are one-cycle pulses that appear in the first cycle SCK shows its new level. With phase 0, sample fires on leading edges and shift on trailing edges. With phase 1 the two are swapped.
- R7: When the sample-swap input is 1, sample fires on the edge opposite to the one given in R6. Shift is unchanged.
- R8: A stop strobe ends the frame after the trailing half of the SCK period in progress. A stop during setup still lets exactly one period run. A stop sampled while no frame is running, or in the same cycle as start, is ignored.
- R9: After the last SCK period completes, CS stays active for (hold count + 1) * P more cycles with SCK at the polarity level.
- R10: frame_done_o pulses for exactly one cycle, (idle count + 1) * P cycles after CS goes inactive. A new start is accepted from that cycle on.
- R11: Counts and mode inputs are captured when start is accepted. Changing them during a frame does not alter that frame.
- R12: CS is active high when the CS-polarity input is 1 and active low when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request strobe |
| stop_i | input | 1 | End-of-frame request strobe |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edges |
| samp_alt_i | input | 1 | Moves sampling to the opposite edge |
| cs_high_i | input | 1 | 1 selects active-high chip select |
| sck_hi_i | input | PW | SCK high phase, cycles minus one |
| sck_lo_i | input | PW | SCK low phase, cycles minus one |
| cs_setup_i | input | PW | Setup, SCK periods minus one |
| cs_hold_i | input | PW | Hold, SCK periods minus one |
| cs_idle_i | input | IDLE_W | Inter-frame gap, SCK periods minus one |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| shift_o | output | 1 | Shift pulse for the data shifter |
| sample_o | output | 1 | Sample pulse for the data shifter |
| frame_done_o | output | 1 | One-cycle frame-complete strobe |

## Verification
The in-line properties check, on every cycle, the following:
- each shift or sample event coincides with an SCK transition in the direction that matches its edge type;
- leading and trailing events never coincide;
- SCK rests at the latched polarity during setup and hold;
- the sequencer enters the running state only from setup or from itself;
- a start sampled while a frame is running never restarts setup;
- frame-done follows only the end of the idle gap.

The exact durations depend on the programmed counts, and only the bench scenarios can show them. These durations are the setup, phase, hold and gap lengths, together with the number of periods after a stop. The bench scenarios also show which edge each pulse lands on under every phase and swap setting, and that a frame ignores configuration changes made while it runs.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_GAP    = 3'd4
  } tmg_state_e;

  // SCK level inside a running period: the first half sits opposite the idle level
  function automatic logic sck_level(input logic cpol, input logic in_first_half);
    return cpol ^ in_first_half;
  endfunction

  // sampling lands on the leading edge when phase and swap agree
  function automatic logic sample_on_lead(input logic cpha, input logic alt);
    return cpha == alt;
  endfunction

  function automatic logic shift_on_lead(input logic cpha);
    return cpha;
  endfunction

  function automatic logic cs_level(input logic active, input logic high_pol);
    return high_pol ? active : ~active;
  endfunction

endpackage

// File: rtl/tmg_phase_timer.sv
module tmg_phase_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] len_a,
  input  logic [PW-1:0] len_b,
  output logic          second_half_o,
  output logic          mid_o,
  output logic          period_end_o
);
  logic [PW-1:0] cnt;
  logic          hf;
  logic          at_zero;

  assign at_zero       = (cnt == '0);
  assign second_half_o = hf;
  assign mid_o         = run & ~restart & ~hf & at_zero;
  assign period_end_o  = run & ~restart & hf & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hf  <= 1'b0;
    end else if (restart) begin
      cnt <= len_a;
      hf  <= 1'b0;
    end else if (run) begin
      if (at_zero) begin
        hf  <= ~hf;
        cnt <= hf ? len_a : len_b;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R4
  half_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_o |=> hf);
endmodule

// File: rtl/tmg_seq.sv
module tmg_seq
  import spi_tmg_pkg::*;
#(
  parameter int UW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          period_end,
  input  logic [UW-1:0] setup_n,
  input  logic [UW-1:0] hold_n,
  input  logic [UW-1:0] idle_n,
  output tmg_state_e    state_o,
  output logic          accept_o,
  output logic          lead_nxt_o,
  output logic          cs_act_o,
  output logic          done_o
);
  tmg_state_e    st;
  logic [UW-1:0] unit;
  logic          stop_pend;
  logic          last_unit;
  logic          stopping;

  assign state_o    = st;
  assign last_unit  = (unit == '0);
  assign stopping   = stop | stop_pend;
  assign accept_o   = start & (st == ST_IDLE);
  assign lead_nxt_o = period_end &
                      (((st == ST_SETUP) & last_unit) | ((st == ST_ACTIVE) & ~stopping));
  assign cs_act_o   = (st == ST_SETUP) | (st == ST_ACTIVE) | (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      unit      <= '0;
      stop_pend <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= (st == ST_GAP) & period_end & last_unit;
      if (accept_o) begin
        st        <= ST_SETUP;
        unit      <= setup_n;
        stop_pend <= 1'b0;
      end else begin
        case (st)
          ST_SETUP: begin
            if (stop) stop_pend <= 1'b1;
            if (period_end) begin
              if (last_unit) st <= ST_ACTIVE;
              else           unit <= unit - 1'b1;
            end
          end
          ST_ACTIVE: begin
            if (stop) stop_pend <= 1'b1;
            if (period_end && stopping) begin
              st        <= ST_HOLD;
              unit      <= hold_n;
              stop_pend <= 1'b0;
            end
          end
          ST_HOLD: begin
            if (period_end) begin
              if (last_unit) begin
                st   <= ST_GAP;
                unit <= idle_n;
              end else begin
                unit <= unit - 1'b1;
              end
            end
          end
          ST_GAP: begin
            if (period_end) begin
              if (last_unit) st <= ST_IDLE;
              else           unit <= unit - 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R3
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE) |-> ($past(st) == ST_SETUP || $past(st) == ST_ACTIVE));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != ST_IDLE && st != ST_SETUP) |=> (st != ST_SETUP));

  // R10
  done_from_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(st) == ST_GAP && st == ST_IDLE));
endmodule

// File: rtl/spi_edge_timer.sv
module spi_edge_timer
  import spi_tmg_pkg::*;
#(
  parameter bit EXT_TIMING = 1'b1,
  parameter int IDLE_W     = 8,
  localparam int PW        = EXT_TIMING ? 16 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              samp_alt_i,
  input  logic              cs_high_i,
  input  logic [PW-1:0]     sck_hi_i,
  input  logic [PW-1:0]     sck_lo_i,
  input  logic [PW-1:0]     cs_setup_i,
  input  logic [PW-1:0]     cs_hold_i,
  input  logic [IDLE_W-1:0] cs_idle_i,
  output logic              sck_o,
  output logic              cs_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic              frame_done_o
);
  localparam int UW = (PW > IDLE_W) ? PW : IDLE_W;

  function automatic logic [PW-1:0] half_len(input logic cpol, input logic first,
                                             input logic [PW-1:0] hi, input logic [PW-1:0] lo);
    return (first ^ cpol) ? hi : lo;
  endfunction

  // configuration captured at frame acceptance
  logic              cpol_l, cpha_l, alt_l, csh_l;
  logic [PW-1:0]     hi_l, lo_l, hold_l;
  logic [IDLE_W-1:0] idle_l;

  tmg_state_e    state;
  logic          accept, lead_nxt, cs_act, done;
  logic          second_half, mid, period_end;
  logic          lead_q, trail_q;
  logic [PW-1:0] len_a, len_b;

  assign len_a = accept ? half_len(cpol_i, 1'b1, sck_hi_i, sck_lo_i)
                        : half_len(cpol_l, 1'b1, hi_l, lo_l);
  assign len_b = accept ? half_len(cpol_i, 1'b0, sck_hi_i, sck_lo_i)
                        : half_len(cpol_l, 1'b0, hi_l, lo_l);

  tmg_phase_timer #(.PW(PW)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (state != ST_IDLE),
    .restart       (accept),
    .len_a         (len_a),
    .len_b         (len_b),
    .second_half_o (second_half),
    .mid_o         (mid),
    .period_end_o  (period_end)
  );

  tmg_seq #(.UW(UW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .stop       (stop_i),
    .period_end (period_end),
    .setup_n    (UW'(cs_setup_i)),
    .hold_n     (UW'(hold_l)),
    .idle_n     (UW'(idle_l)),
    .state_o    (state),
    .accept_o   (accept),
    .lead_nxt_o (lead_nxt),
    .cs_act_o   (cs_act),
    .done_o     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_l <= 1'b0;
      cpha_l <= 1'b0;
      alt_l  <= 1'b0;
      csh_l  <= 1'b0;
      hi_l   <= '0;
      lo_l   <= '0;
      hold_l <= '0;
      idle_l <= '0;
    end else if (accept) begin
      cpol_l <= cpol_i;
      cpha_l <= cpha_i;
      alt_l  <= samp_alt_i;
      csh_l  <= cs_high_i;
      hi_l   <= sck_hi_i;
      lo_l   <= sck_lo_i;
      hold_l <= cs_hold_i;
      idle_l <= cs_idle_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= lead_nxt;
      trail_q <= (state == ST_ACTIVE) & mid;
    end
  end

  always_comb begin
    if (state == ST_ACTIVE)    sck_o = sck_level(cpol_l, ~second_half);
    else if (state == ST_IDLE) sck_o = cpol_i;
    else                       sck_o = cpol_l;
  end

  assign cs_o         = cs_level(cs_act, (state == ST_IDLE) ? cs_high_i : csh_l);
  assign sample_o     = sample_on_lead(cpha_l, alt_l) ? lead_q : trail_q;
  assign shift_o      = shift_on_lead(cpha_l) ? lead_q : trail_q;
  assign frame_done_o = done;

  // R6
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sck_o != cpol_l && $past(sck_o) == cpol_l));

  // R6
  trail_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sck_o == cpol_l && $past(sck_o) != cpol_l));

  // R6
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_q, trail_q}));

  // R9
  rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && state != ST_ACTIVE) |-> (sck_o == cpol_l));
endmodule

// File: tb/sim_spi_edge_timer.sv
`timescale 1ns/1ps
module sim_spi_edge_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, alt = 1'b0, csh = 1'b0;
  logic [15:0] hi = '0, lo = '0, su = '0, ho = '0;
  logic [7:0]  idl = '0;
  logic        sck_o, cs_o, shift_o, sample_o, frame_done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  spi_edge_timer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .cpol_i(cpol), .cpha_i(cpha), .samp_alt_i(alt), .cs_high_i(csh),
    .sck_hi_i(hi), .sck_lo_i(lo), .cs_setup_i(su), .cs_hold_i(ho), .cs_idle_i(idl),
    .sck_o(sck_o), .cs_o(cs_o), .shift_o(shift_o), .sample_o(sample_o),
    .frame_done_o(frame_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cpol = 1'b1; csh = 1'b0;
    repeat (3) @(negedge clk);
    chk(sck_o == 1'b1, "R1 sck at polarity in reset", sck_o, 1);
    chk(cs_o == 1'b1, "R12 active-low cs idles high", cs_o, 1);
    chk({shift_o, sample_o, frame_done_o} == 3'b000, "R1 pulses low in reset",
        {shift_o, sample_o, frame_done_o}, 0);
    cpol = 1'b0; csh = 1'b1;
    @(negedge clk);
    chk(cs_o == 1'b0 && sck_o == 1'b0, "R1 idle levels follow inputs", {cs_o, sck_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_stop_idle();
    int activity = 0;
    csh = 1'b0;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cs_o != 1'b1 || frame_done_o || shift_o || sample_o) activity++;
    end
    chk(activity == 0, "R8 stop while idle ignored", activity, 0);
  endtask

  task automatic run_frame(input bit c_pol, input bit c_pha, input bit c_alt, input bit c_csh,
                           input int h, input int l, input int s, input int hd, input int gi,
                           input int nstop, input bit prestop, input bit disturb);
    int  per = (h + 1) + (l + 1);
    int  l1 = c_pol ? l : h;
    int  l2 = c_pol ? h : l;
    bit  samp_lead = (c_pha == c_alt);
    bit  shift_lead = c_pha;
    int  k = 0, leads = 0, last_edge = -1, first_lead = -1, last_trail = -1;
    int  k_on = -1, k_off = -1, k_done = -1;
    int  ph_err = 0, samp_err = 0, shift_err = 0;
    int  exp_leads = (nstop == 0) ? 1 : nstop;
    bit  prev = c_pol, edge_seen, is_lead, sck_first = 1'b0;

    @(negedge clk);
    cpol = c_pol; cpha = c_pha; alt = c_alt; csh = c_csh;
    hi = 16'(h); lo = 16'(l); su = 16'(s); ho = 16'(hd); idl = 8'(gi);
    start = 1'b1; stop = prestop;
    while (k_done < 0 && k < 20000) begin
      @(negedge clk);
      k++;
      start = 1'b0; stop = 1'b0;
      if (disturb && k == 2) begin
        start = 1'b1;
        hi = 16'(h + 3); lo = 16'(l + 2); su = 16'(s + 1); ho = 16'(hd + 2);
        idl = 8'(gi + 1); cpha = ~c_pha; alt = ~c_alt;
      end
      if (k == 1) sck_first = sck_o;
      if (k_on < 0 && cs_o == c_csh) k_on = k;
      if (k_on >= 0 && k_off < 0 && cs_o != c_csh) k_off = k;
      edge_seen = (sck_o != prev);
      is_lead = edge_seen && (sck_o != c_pol);
      if (edge_seen) begin
        if (is_lead) begin
          leads++;
          if (first_lead < 0) first_lead = k;
          else if (k - last_edge != l2 + 1) ph_err++;
        end else begin
          if (k - last_edge != l1 + 1) ph_err++;
          last_trail = k;
        end
        last_edge = k;
      end
      if (sample_o != (edge_seen && (is_lead == samp_lead))) samp_err++;
      if (shift_o != (edge_seen && (is_lead == shift_lead))) shift_err++;
      if (nstop == 0 ? (k == 1) : (is_lead && leads == nstop)) stop = 1'b1;
      if (frame_done_o) k_done = k;
      prev = sck_o;
    end
    @(negedge clk);
    chk(frame_done_o == 1'b0, "R10 done lasts one cycle", frame_done_o, 0);
    chk(cs_o == !c_csh, "R12 cs back at inactive level", cs_o, !c_csh);
    chk(k_on == 1, "R2 cs asserts cycle after start", k_on, 1);
    chk(sck_first == c_pol, "R5 sck rests at polarity during setup", sck_first, c_pol);
    chk(first_lead - k_on == (s + 1) * per, "R3 setup length", first_lead - k_on, (s + 1) * per);
    chk(ph_err == 0, "R4 phase lengths", ph_err, 0);
    chk(leads == exp_leads, "R8 periods after stop", leads, exp_leads);
    chk(k_off - last_trail == (l2 + 1) + (hd + 1) * per, "R9 hold length",
        k_off - last_trail, (l2 + 1) + (hd + 1) * per);
    chk(k_done - k_off == (gi + 1) * per, "R10 gap length", k_done - k_off, (gi + 1) * per);
    if (c_alt) chk(samp_err == 0, "R7 sample on swapped edge", samp_err, 0);
    else       chk(samp_err == 0, "R6 sample edge", samp_err, 0);
    chk(shift_err == 0, "R6 shift edge", shift_err, 0);
    if (disturb) chk(ph_err == 0 && leads == exp_leads, "R11 config held during frame", ph_err, 0);
    cpha = c_pha; alt = c_alt;
    hi = 16'(h); lo = 16'(l); su = 16'(s); ho = 16'(hd); idl = 8'(gi);
  endtask

  task automatic t_basic();      run_frame(1'b0, 1'b0, 1'b0, 1'b0, 1, 2, 0, 0, 0, 3, 1'b0, 1'b0); endtask
  task automatic t_fast_pol1();  run_frame(1'b1, 1'b1, 1'b0, 1'b1, 0, 0, 2, 1, 2, 2, 1'b0, 1'b0); endtask
  task automatic t_swap();       run_frame(1'b0, 1'b0, 1'b1, 1'b0, 2, 1, 1, 0, 1, 1, 1'b0, 1'b0); endtask
  task automatic t_setup_stop(); run_frame(1'b1, 1'b1, 1'b1, 1'b0, 3, 0, 1, 2, 0, 0, 1'b1, 1'b0); endtask
  task automatic t_busy_start(); run_frame(1'b0, 1'b1, 1'b0, 1'b1, 2, 3, 1, 1, 1, 4, 1'b0, 1'b1); endtask

  initial begin
    t_reset();
    t_stop_idle();
    t_basic();
    t_fast_pol1();
    t_swap();
    t_setup_stop();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule